// File: doc/BRIEF.md
# Coax Modem Half-Duplex Direction Controller

This block sits between an on-off-keyed coax modem and an RS-485 segment and decides, cycle by cycle, which way the half-duplex link points. It has three modes: idle, receive and transmit. Activity picks the mode. A valid incoming carrier puts the block in receive. A low level on the transmit data line puts it in transmit. Once one direction is taken, the other cannot take over until the link has been quiet for a timeout of about sixteen bit times.

In receive, the direction output goes high so that the remote RS-485 drivers pass the incoming message on. In transmit, the direction output stays low and a force-idle signal holds the local receiver's data output high. The transmit carrier, a divide-by-four of the 8.704 MHz reference clock, is gated by a registered transmit enable.

A two-bit rate code sets the timeout length. Three codes select a signalling rate. The fourth code selects standby: the transmitter is then shut off, while reception keeps working.

Top module: `coax_dir_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mode reads 2'b00 (idle), and dir_out, tx_en, rx_force_idle and tx_carrier are all 0.
- R2: In idle, carrier_valid high at a clock edge moves mode to 2'b01 (receive) at that edge, and dir_out reads 1 from then on.
- R3: In idle with rate_code not 2'b11, tx_data low at a clock edge moves mode to 2'b10 (transmit) at that edge. From then on rx_force_idle reads 1 and dir_out reads 0.
- R4: In idle, when carrier_valid is high and tx_data is low at the same edge, receive wins: mode becomes 2'b01.
- R5: In receive, tx_data low does not change the mode. In transmit, carrier_valid does not change the mode. dir_out and rx_force_idle are never both 1.
- R6: Activity reloads the timeout. In receive, activity is carrier_valid or rx_rise high. In transmit, activity is tx_data low. The mode returns to idle exactly N clock edges after the last edge that sampled activity, where N is the reload length of the current rate.
- R7: The reload length N is SLOW_CYC for rate_code 2'b00, MID_CYC for 2'b01, FAST_CYC for 2'b10, and SLOW_CYC for 2'b11 (standby). The defaults are 14509, 3630 and 1192 cycles.
- R8: With rate_code 2'b11, tx_en and tx_carrier stay 0 from the next edge onward, and idle ignores tx_data low. Receive entry and dir_out still work as in R2.
- R9: In receive or transmit with rate_code not 2'b11, tx_en equals the inverse of tx_data as registered at the previous edge.
- R10: tx_carrier is the reference clock divided by 4, with a 50% duty cycle, ANDed with tx_en. It therefore reads 1 on 4 of any 8 consecutive cycles while tx_en is 1, and 0 while tx_en is 0.
- R11: A change of rate_code during a running countdown does not alter that countdown. The new length applies from the next reload.
- R12: An rx_rise pulse during a receive countdown restarts the full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.704 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Baseband transmit data; low means carrier on |
| rate_code | input | 2 | Rate select: 00 slow, 01 mid, 10 fast, 11 standby |
| carrier_valid | input | 1 | Receiver has detected a valid carrier |
| rx_rise | input | 1 | One-cycle pulse on a rising edge of the received data |
| dir_out | output | 1 | High while received data is passed on to RS-485 |
| tx_en | output | 1 | Transmit carrier enable |
| tx_carrier | output | 1 | Gated divide-by-four carrier |
| mode | output | 2 | Current mode: 00 idle, 01 receive, 10 transmit |
| rx_force_idle | output | 1 | Holds the receiver's data output high while transmitting |

## Verification
Two pairs of events can land in the same cycle. The first pair is the two entry conditions from idle: the bench raises carrier_valid and lowers tx_data on the same falling edge, then judges by mode and dir_out one edge later that receive was chosen. The second pair is a timeout expiry and a reload. The bench applies an rx_rise pulse late in a countdown and counts edges to confirm the full length restarts. It also changes the rate code mid-countdown and counts edges to confirm the running count keeps its old length.

// File: rtl/coax_dir_pkg.sv
package coax_dir_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RX   = 2'b01,
        MODE_TX   = 2'b10
    } dir_mode_e;

    localparam logic [1:0] RATE_SLOW    = 2'b00;
    localparam logic [1:0] RATE_MID     = 2'b01;
    localparam logic [1:0] RATE_FAST    = 2'b10;
    localparam logic [1:0] RATE_STANDBY = 2'b11;

endpackage

// File: rtl/coax_dir_rate.sv
module coax_dir_rate
    import coax_dir_pkg::*;
#(
    parameter int SLOW_CYC = 14509,
    parameter int MID_CYC  = 3630,
    parameter int FAST_CYC = 1192,
    parameter int CNT_W    = 14
) (
    input  logic [1:0]       rate_code,
    output logic [CNT_W-1:0] reload_val,
    output logic             standby
);

    always_comb begin
        standby = (rate_code == RATE_STANDBY);
        unique case (rate_code)
            RATE_MID:  reload_val = CNT_W'(MID_CYC);
            RATE_FAST: reload_val = CNT_W'(FAST_CYC);
            default:   reload_val = CNT_W'(SLOW_CYC);
        endcase
    end

endmodule

// File: rtl/coax_dir_timer.sv
module coax_dir_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - CNT_W'(1);
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R6: a reload starts the countdown one below the selected length
    a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val) - CNT_W'(1)));

    // R11: without a reload the count never grows
    a_r11_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/coax_dir_carrier.sv
module coax_dir_carrier #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic tx_carrier
);

    logic [DIV_LOG2-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + DIV_LOG2'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tx_carrier = div_q[DIV_LOG2-1] & tx_en;

    // R10: no carrier without the enable
    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_carrier |-> tx_en);

endmodule

// File: rtl/coax_dir_ctrl.sv
module coax_dir_ctrl
    import coax_dir_pkg::*;
#(
    parameter int SLOW_CYC = 14509,
    parameter int MID_CYC  = 3630,
    parameter int FAST_CYC = 1192,
    parameter int DIV_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_data,
    input  logic [1:0] rate_code,
    input  logic       carrier_valid,
    input  logic       rx_rise,
    output logic       dir_out,
    output logic       tx_en,
    output logic       tx_carrier,
    output logic [1:0] mode,
    output logic       rx_force_idle
);

    localparam int MAX_CYC = (SLOW_CYC > MID_CYC)
                           ? ((SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC)
                           : ((MID_CYC  > FAST_CYC) ? MID_CYC  : FAST_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        dir_mode_e mode;
        logic      dir;
        logic      txen;
        logic      force_idle;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt;
    logic             standby;
    logic             load;
    logic             dec;
    logic             act_rx;
    logic             act_tx;

    coax_dir_rate #(
        .SLOW_CYC (SLOW_CYC),
        .MID_CYC  (MID_CYC),
        .FAST_CYC (FAST_CYC),
        .CNT_W    (CNT_W)
    ) u_rate (
        .rate_code  (rate_code),
        .reload_val (reload_val),
        .standby    (standby)
    );

    coax_dir_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .dec      (dec),
        .load_val (reload_val),
        .cnt      (cnt)
    );

    coax_dir_carrier #(
        .DIV_LOG2 (DIV_LOG2)
    ) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (st_q.txen),
        .tx_carrier (tx_carrier)
    );

    always_comb begin
        act_rx  = carrier_valid | rx_rise;
        act_tx  = ~tx_data;
        st_d    = st_q;
        load    = 1'b0;
        dec     = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (carrier_valid) begin
                    st_d.mode = MODE_RX;
                    load      = 1'b1;
                end else if (act_tx && !standby) begin
                    st_d.mode = MODE_TX;
                    load      = 1'b1;
                end
            end
            MODE_RX: begin
                if (act_rx)             load      = 1'b1;
                else if (cnt == '0)     st_d.mode = MODE_IDLE;
                else                    dec       = 1'b1;
            end
            MODE_TX: begin
                if (act_tx)             load      = 1'b1;
                else if (cnt == '0)     st_d.mode = MODE_IDLE;
                else                    dec       = 1'b1;
            end
            default: st_d.mode = MODE_IDLE;
        endcase
        st_d.dir        = (st_d.mode == MODE_RX);
        st_d.force_idle = (st_d.mode == MODE_TX);
        st_d.txen       = (st_d.mode != MODE_IDLE) && act_tx && !standby;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, dir: 1'b0, txen: 1'b0, force_idle: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_out       = st_q.dir;
    assign tx_en         = st_q.txen;
    assign mode          = st_q.mode;
    assign rx_force_idle = st_q.force_idle;

    // R5: both directions are never claimed together
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_out && rx_force_idle));

    // R6: a nonzero count keeps an active mode alive
    a_r6_hold_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_IDLE && cnt != '0) |=> (mode != MODE_IDLE));

    // R8: the standby code silences the transmitter at the next edge
    a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == RATE_STANDBY) |=> !tx_en);

    // R9: no transmit enable while idle
    a_r9_enable_active: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (mode != MODE_IDLE));

    // R2: the direction output goes with receive mode
    a_r2_dir_rx: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |-> (mode == MODE_RX));

endmodule

// File: tb/coax_dir_ctrl_tb.sv
module coax_dir_ctrl_tb;

    localparam int SLOW = 40;
    localparam int MID  = 20;
    localparam int FAST = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_data = 1'b1;
    logic [1:0] rate_code = 2'b00;
    logic       carrier_valid = 1'b0;
    logic       rx_rise = 1'b0;
    logic       dir_out, tx_en, tx_carrier, rx_force_idle;
    logic [1:0] mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    coax_dir_ctrl #(
        .SLOW_CYC (SLOW),
        .MID_CYC  (MID),
        .FAST_CYC (FAST),
        .DIV_LOG2 (2)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_data       (tx_data),
        .rate_code     (rate_code),
        .carrier_valid (carrier_valid),
        .rx_rise       (rx_rise),
        .dir_out       (dir_out),
        .tx_en         (tx_en),
        .tx_carrier    (tx_carrier),
        .mode          (mode),
        .rx_force_idle (rx_force_idle)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst_n = 1'b0; tx_data = 1'b1; carrier_valid = 1'b0; rx_rise = 1'b0;
        rate_code = code;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        chk("R1", "mode", mode, 0);
        chk("R1", "dir_out", dir_out, 0);
        chk("R1", "tx_en", tx_en, 0);
        chk("R1", "rx_force_idle", rx_force_idle, 0);
        chk("R1", "tx_carrier", tx_carrier, 0);
    endtask

    task automatic t_rx_entry();
        do_reset(2'b00);
        carrier_valid = 1'b1; step(1);
        chk("R2", "mode", mode, 1);
        chk("R2", "dir_out", dir_out, 1);
        carrier_valid = 1'b0; step(SLOW - 1);
        chk("R6", "rx mode before timeout", mode, 1);
        step(1);
        chk("R6", "rx mode after timeout", mode, 0);
        chk("R6", "dir_out after timeout", dir_out, 0);
    endtask

    task automatic t_tx_entry();
        do_reset(2'b01);
        tx_data = 1'b0; step(1);
        chk("R3", "mode", mode, 2);
        chk("R3", "rx_force_idle", rx_force_idle, 1);
        chk("R3", "dir_out", dir_out, 0);
        chk("R9", "tx_en low data", tx_en, 1);
        step(3);
        tx_data = 1'b1; step(1);
        chk("R9", "tx_en high data", tx_en, 0);
        step(MID - 2);
        chk("R6", "tx mode before timeout", mode, 2);
        step(1);
        chk("R6", "tx mode after timeout", mode, 0);
        chk("R3", "rx_force_idle after timeout", rx_force_idle, 0);
    endtask

    task automatic t_carrier();
        int ones;
        int rises;
        logic prev;
        do_reset(2'b00);
        tx_data = 1'b0; step(1);
        ones = 0; rises = 0; prev = tx_carrier;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (tx_carrier) ones++;
            if (tx_carrier && !prev) rises++;
            prev = tx_carrier;
        end
        chk("R10", "carrier high cycles in 8", ones, 4);
        chk("R10", "carrier rising edges in 8", rises, 2);
        tx_data = 1'b1; step(1);
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            if (tx_carrier) ones++;
            step(1);
        end
        chk("R10", "carrier while disabled", ones, 0);
    endtask

    task automatic t_simul();
        do_reset(2'b00);
        carrier_valid = 1'b1; tx_data = 1'b0; step(1);
        chk("R4", "mode", mode, 1);
        chk("R4", "dir_out", dir_out, 1);
        chk("R4", "rx_force_idle", rx_force_idle, 0);
        chk("R9", "tx_en in receive", tx_en, 1);
    endtask

    task automatic t_excl();
        do_reset(2'b00);
        carrier_valid = 1'b1; step(1);
        tx_data = 1'b0; step(3);
        chk("R5", "rx kept with tx low", mode, 1);
        chk("R5", "rx_force_idle in rx", rx_force_idle, 0);
        do_reset(2'b00);
        tx_data = 1'b0; step(1);
        carrier_valid = 1'b1; step(3);
        chk("R5", "tx kept with carrier", mode, 2);
        chk("R5", "dir_out in tx", dir_out, 0);
    endtask

    task automatic t_rates();
        int len;
        for (int c = 0; c < 4; c++) begin
            len = (c == 1) ? MID : (c == 2) ? FAST : SLOW;
            do_reset(c[1:0]);
            carrier_valid = 1'b1; step(1);
            carrier_valid = 1'b0; step(len - 1);
            chk("R7", $sformatf("code %0d before end", c), mode, 1);
            step(1);
            chk("R7", $sformatf("code %0d after end", c), mode, 0);
        end
    endtask

    task automatic t_standby();
        do_reset(2'b11);
        tx_data = 1'b0; step(3);
        chk("R8", "idle ignores tx", mode, 0);
        chk("R8", "tx_en idle", tx_en, 0);
        carrier_valid = 1'b1; step(1);
        chk("R8", "rx works mode", mode, 1);
        chk("R8", "rx works dir", dir_out, 1);
        step(1);
        chk("R8", "tx_en in rx", tx_en, 0);
        chk("R8", "tx_carrier in rx", tx_carrier, 0);
        do_reset(2'b00);
        tx_data = 1'b0; step(2);
        rate_code = 2'b11; step(1);
        chk("R8", "tx_en after switch", tx_en, 0);
        chk("R8", "mode after switch", mode, 2);
    endtask

    task automatic t_ratechg();
        do_reset(2'b10);
        tx_data = 1'b0; step(1);
        tx_data = 1'b1; step(2);
        rate_code = 2'b00; step(FAST - 3);
        chk("R11", "tx before old end", mode, 2);
        step(1);
        chk("R11", "tx ends at old length", mode, 0);
        do_reset(2'b10);
        carrier_valid = 1'b1; step(1);
        carrier_valid = 1'b0; rate_code = 2'b01; step(2);
        rx_rise = 1'b1; step(1);
        rx_rise = 1'b0; step(MID - 1);
        chk("R11", "new length after reload", mode, 1);
        step(1);
        chk("R11", "end at new length", mode, 0);
    endtask

    task automatic t_restart();
        do_reset(2'b01);
        carrier_valid = 1'b1; step(1);
        carrier_valid = 1'b0; step(MID - 3);
        rx_rise = 1'b1; step(1);
        rx_rise = 1'b0; step(MID - 1);
        chk("R12", "rx held after restart", mode, 1);
        step(1);
        chk("R12", "rx ends after full length", mode, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rx_entry();
        t_tx_entry();
        t_carrier();
        t_simul();
        t_excl();
        t_rates();
        t_standby();
        t_ratechg();
        t_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule